// File: doc/BRIEF.md
# Keyboard Serial Host Receiver

This block sits inside a system gate array and collects scancodes from a PC-XT style keyboard. It watches the keyboard clock and data lines and shifts in one byte per frame. The byte is kept in a shift register that the processor may read at any moment, even while the bits are still arriving. When a byte is complete, an active-low availability flag drops. That same level serves as the interrupt request.

Software steers the link through two control bits. The clock-control bit drives the keyboard clock line directly, so writing 0 holds the keyboard off. The receive-control bit has two uses. Writing 0 wipes the receiver and lets go of the data line. Writing 1 arms the receiver to accept the next frame on its own.

After a byte lands, the host holds the data line low until software clears the receiver. This stops the keyboard from sending another code. Both keyboard lines are modelled as open-drain pull-down enables, and each input seen by the block is the wired-AND of both ends.

Top module: `kbx_host_rx`

## Requirements
- R1: A frame is a 0 start bit, a second start bit, then 8 data bits least significant first, each sampled on a falling edge of the synchronized keyboard clock; after the frame the scancode reads back as the sent byte.
- R2: While a frame arrives, after k data bits the read port returns the first k bits in its top k positions, the latest bit in bit 7 and zeros below: (byte << (8-k)) mod 256.
- R3: avail_n stays 1 until the last data bit of a frame has been sampled, then goes to 0 and acts as the active-low interrupt.
- R4: Writing 0 to the receive-control bit (ctl_sel=1) clears the scancode to 0, returns avail_n to 1 and releases the data line (kb_dat_pd=0).
- R5: While the receive-control bit is 0, keyboard clock edges have no effect and the scancode stays 0.
- R6: Once a byte is complete, kb_dat_pd is 1, and further clock edges leave the scancode and avail_n unchanged until the receive-control bit is written 0.
- R7: The clock-control bit (ctl_sel=0) drives the clock line: 0 gives kb_clk_pd=1 and inhibits reception, 1 gives kb_clk_pd=0.
- R8: The read port hits for any address whose bits above the lowest 3 equal those of RD_BASE (0xF118 to 0xF11F by default); otherwise rd_hit=0 and rd_data=0.
- R9: A falling clock edge that samples 1 while the receiver waits for a frame does not start a frame.
- R10: Clearing the receiver in mid-frame discards the partial byte and resets the bit count; a later frame is received intact.
- R11: After reset the clock-control bit is 1, the receive-control bit is 0 (ctl_q=2'b01), avail_n=1, both pull-downs are off, and the scancode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_clk_in | input | 1 | Keyboard clock line level |
| kb_dat_in | input | 1 | Keyboard data line level |
| kb_clk_pd | output | 1 | Pull-down enable for the clock line |
| kb_dat_pd | output | 1 | Pull-down enable for the data line |
| ctl_wr | input | 1 | Control bit write strobe |
| ctl_sel | input | 1 | 0 = clock-control bit, 1 = receive-control bit |
| ctl_wdata | input | 1 | Value written to the selected bit |
| ctl_q | output | 2 | Control bits readback {receive, clock} |
| rd_addr | input | 16 | Read address |
| rd_hit | output | 1 | Address decodes to the scancode register |
| rd_data | output | 8 | Scancode register contents when hit, else 0 |
| avail_n | output | 1 | Byte available, active low; also the interrupt request |

## Verification
The bench uses the default parameters: 8 data bits, two start bits, a two-stage synchronizer and a 16-bit address with 3 aliased bits. At 8 data bits the bench can send all 256 scancodes. For each one it checks every partially shifted value, the completion flag and the held data line. The keyboard model drives its lines through the same wired-AND as the hardware. This makes clock inhibit, data hold-off and stray edges observable, along with the aliased and missed read addresses.

// File: rtl/kbx_pkg.sv
package kbx_pkg;
  typedef enum logic {
    SEL_CLK = 1'b0,
    SEL_RX  = 1'b1
  } kbx_sel_e;

  localparam int unsigned CTL_CLK_IDX = 0;
  localparam int unsigned CTL_RX_IDX  = 1;
endpackage

// File: rtl/kbx_sync.sv
module kbx_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/kbx_ctl.sv
module kbx_ctl
  import kbx_pkg::*;
#(
  parameter logic CLK_CTL_RST = 1'b1,
  parameter logic RX_CTL_RST  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       sel_i,
  input  logic       wdata_i,
  output logic [1:0] ctl_o
);
  kbx_sel_e   sel;
  logic       clk_en, rx_en;
  logic [1:0] ctl_q, ctl_d;

  assign sel    = kbx_sel_e'(sel_i);
  assign clk_en = wr_i && (sel == SEL_CLK);
  assign rx_en  = wr_i && (sel == SEL_RX);

  always_comb begin
    ctl_d = ctl_q;
    if (clk_en) ctl_d[CTL_CLK_IDX] = wdata_i;
    if (rx_en)  ctl_d[CTL_RX_IDX]  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q[CTL_CLK_IDX] <= CLK_CTL_RST;
      ctl_q[CTL_RX_IDX]  <= RX_CTL_RST;
    end else if (clk_en || rx_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl_o = ctl_q;

  // R11 / R7: a write lands in the addressed bit only
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == 1'b0) |=> (ctl_q[CTL_CLK_IDX] == $past(wdata_i))
                              && $stable(ctl_q[CTL_RX_IDX]));
endmodule

// File: rtl/kbx_frame.sv
module kbx_frame #(
  parameter int unsigned DATA_BITS  = 8,
  parameter int unsigned START_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_i,
  input  logic                 clk_s_i,
  input  logic                 dat_s_i,
  output logic [DATA_BITS-1:0] sr_o,
  output logic                 full_o,
  output logic                 dat_pd_o
);
  localparam int unsigned FRAME_BITS = DATA_BITS + START_BITS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(START_BITS);

  logic                 clk_prev_q;
  logic                 fall;
  logic [DATA_BITS-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 full_q, full_d;

  assign fall = clk_prev_q & ~clk_s_i;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    if (!arm_i) begin
      sr_d   = '0;
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (fall && !full_q) begin
      if (cnt_q == '0) begin
        if (!dat_s_i) cnt_d = CNT_W'(1);
      end else if (cnt_q < CNT_FIRST) begin
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        sr_d = {dat_s_i, sr_q[DATA_BITS-1:1]};
        if (cnt_q == CNT_LAST) begin
          cnt_d  = '0;
          full_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b1;
      sr_q       <= '0;
      cnt_q      <= '0;
      full_q     <= 1'b0;
    end else begin
      clk_prev_q <= clk_s_i;
      sr_q       <= sr_d;
      cnt_q      <= cnt_d;
      full_q     <= full_d;
    end
  end

  assign sr_o     = sr_q;
  assign full_o   = full_q;
  assign dat_pd_o = full_q;

  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> ($past(cnt_q) == CNT_LAST));

  a_r6_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && arm_i) |=> (full_q && $stable(sr_q)));

  a_r2_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !full_q && fall && cnt_q >= CNT_FIRST)
      |=> (sr_q[DATA_BITS-2:0] == $past(sr_q[DATA_BITS-1:1])));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!arm_i) |-> (sr_q == '0 && !full_q));
endmodule

// File: rtl/kbx_rdport.sv
module kbx_rdport #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ALIAS_BITS = 3,
  parameter int unsigned DATA_BITS  = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'hF118
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_BITS-1:0] sr_i,
  output logic                 hit_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIAS_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] HI_MASK  = ~LOW_MASK;

  assign hit_o  = (addr_i & HI_MASK) == (BASE & HI_MASK);
  assign data_o = hit_o ? sr_i : '0;
endmodule

// File: rtl/kbx_host_rx.sv
module kbx_host_rx
  import kbx_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned START_BITS  = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned ALIAS_BITS  = 3,
  parameter logic [ADDR_W-1:0] RD_BASE = 16'hF118,
  parameter logic CLK_CTL_RST = 1'b1,
  parameter logic RX_CTL_RST  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kb_clk_in,
  input  logic                 kb_dat_in,
  output logic                 kb_clk_pd,
  output logic                 kb_dat_pd,
  input  logic                 ctl_wr,
  input  logic                 ctl_sel,
  input  logic                 ctl_wdata,
  output logic [1:0]           ctl_q,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_hit,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 avail_n
);
  logic [1:0]           line_s;
  logic [1:0]           ctl;
  logic [DATA_BITS-1:0] sr;
  logic                 full;
  logic                 dat_pd;

  kbx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({kb_dat_in, kb_clk_in}),
    .q_o  (line_s)
  );

  kbx_ctl #(.CLK_CTL_RST(CLK_CTL_RST), .RX_CTL_RST(RX_CTL_RST)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (ctl_wr),
    .sel_i  (ctl_sel),
    .wdata_i(ctl_wdata),
    .ctl_o  (ctl)
  );

  kbx_frame #(.DATA_BITS(DATA_BITS), .START_BITS(START_BITS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (ctl[CTL_RX_IDX]),
    .clk_s_i (line_s[0]),
    .dat_s_i (line_s[1]),
    .sr_o    (sr),
    .full_o  (full),
    .dat_pd_o(dat_pd)
  );

  kbx_rdport #(
    .ADDR_W(ADDR_W), .ALIAS_BITS(ALIAS_BITS),
    .DATA_BITS(DATA_BITS), .BASE(RD_BASE)
  ) u_rd (
    .addr_i(rd_addr),
    .sr_i  (sr),
    .hit_o (rd_hit),
    .data_o(rd_data)
  );

  assign kb_clk_pd = ~ctl[CTL_CLK_IDX];
  assign kb_dat_pd = dat_pd;
  assign avail_n   = ~full;
  assign ctl_q     = ctl;

  a_r7_clk_line: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_sel == 1'b0) |=> (kb_clk_pd == !$past(ctl_wdata)));

  a_r4_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_sel == 1'b1 && !ctl_wdata) |=> ##1 (avail_n && !kb_dat_pd));
endmodule

// File: tb/sim_kbx_host_rx.sv
module sim_kbx_host_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kc_drv = 1'b1, kd_drv = 1'b1;
  logic        kb_clk_in, kb_dat_in, kb_clk_pd, kb_dat_pd;
  logic        ctl_wr = 1'b0, ctl_sel = 1'b0, ctl_wdata = 1'b0;
  logic [1:0]  ctl_q;
  logic [15:0] rd_addr = 16'hF118;
  logic        rd_hit, avail_n;
  logic [7:0]  rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign kb_clk_in = kc_drv & ~kb_clk_pd;
  assign kb_dat_in = kd_drv & ~kb_dat_pd;

  kbx_host_rx u0 (
    .clk(clk), .rst_n(rst_n), .kb_clk_in(kb_clk_in), .kb_dat_in(kb_dat_in),
    .kb_clk_pd(kb_clk_pd), .kb_dat_pd(kb_dat_pd), .ctl_wr(ctl_wr),
    .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data), .avail_n(avail_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wctl(input logic sel, input logic val);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_sel = sel; ctl_wdata = val;
    @(negedge clk);
    ctl_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    kd_drv = b;
    repeat (3) @(negedge clk);
    kc_drv = 1'b0;
    repeat (5) @(negedge clk);
    kc_drv = 1'b1;
    repeat (3) @(negedge clk);
    kd_drv = 1'b1;
  endtask

  // sends the frame; when watch is set, checks each partial value (R2, R3)
  task automatic send_frame(input logic [7:0] b, input bit watch);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int k = 1; k <= 8; k++) begin
      send_bit(b[k-1]);
      if (watch) begin
        rd_addr = 16'hF118;
        #1;
        chk("R2 partial", rd_data, 32'((16'(b) << (8 - k)) & 16'hFF));
        if (k < 8) chk("R3 idle until last", avail_n, 1);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 avail_n", avail_n, 1);
    chk("R11 clk_pd", kb_clk_pd, 0);
    chk("R11 dat_pd", kb_dat_pd, 0);
    chk("R11 ctl_q", ctl_q, 2'b01);
    chk("R11 scancode", rd_data, 0);

    // R5: receiver disarmed, frame has no effect
    send_frame(8'h5A, 1'b0);
    chk("R5 stays zero", rd_data, 0);
    chk("R5 no avail", avail_n, 1);

    wctl(1'b1, 1'b1);
    chk("R4 arm readback", ctl_q, 2'b11);

    // R1 R2 R3 R6 R4 full sweep
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b1);
      chk("R1 byte", rd_data, v);
      chk("R3 avail low", avail_n, 0);
      chk("R6 data held", kb_dat_pd, 1);
      if (v % 64 == 7) begin
        send_frame(8'(~v), 1'b0);
        chk("R6 ignored byte", rd_data, v);
        chk("R6 still avail", avail_n, 0);
      end
      wctl(1'b1, 1'b0);
      chk("R4 cleared", rd_data, 0);
      chk("R4 avail high", avail_n, 1);
      chk("R4 data released", kb_dat_pd, 0);
      wctl(1'b1, 1'b1);
    end

    // R9: stray edges sampling 1 do not start a frame
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b1);
    chk("R9 no start", avail_n, 1);
    send_frame(8'hC3, 1'b0);
    chk("R9 frame after strays", rd_data, 8'hC3);
    wctl(1'b1, 1'b0);
    wctl(1'b1, 1'b1);

    // R10: mid-frame clear discards partial
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b1);
    wctl(1'b1, 1'b0);
    chk("R10 discarded", rd_data, 0);
    wctl(1'b1, 1'b1);
    send_frame(8'h81, 1'b0);
    chk("R10 clean frame", rd_data, 8'h81);
    chk("R10 avail", avail_n, 0);
    wctl(1'b1, 1'b0);
    wctl(1'b1, 1'b1);

    // R7: clock inhibit
    wctl(1'b0, 1'b0);
    chk("R7 clk pulled", kb_clk_pd, 1);
    send_frame(8'h77, 1'b0);
    chk("R7 inhibited", avail_n, 1);
    chk("R7 no data", rd_data, 0);
    wctl(1'b0, 1'b1);
    chk("R7 clk released", kb_clk_pd, 0);
    send_frame(8'hA5, 1'b0);
    chk("R7 receive after release", rd_data, 8'hA5);

    // R8: address aliasing
    for (int a = 16'hF110; a < 16'hF128; a++) begin
      @(negedge clk);
      rd_addr = 16'(a);
      #1;
      if (a >= 16'hF118 && a <= 16'hF11F) begin
        chk("R8 hit", rd_hit, 1);
        chk("R8 data", rd_data, 8'hA5);
      end else begin
        chk("R8 miss", rd_hit, 0);
        chk("R8 miss data", rd_data, 0);
      end
    end
    @(negedge clk);
    rd_addr = 16'h0000;
    #1;
    chk("R8 far miss", rd_data, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule